// File: doc/BRIEF.md
# Configurable UART Frame Transmitter

This block turns bytes into asynchronous serial frames. Bytes enter through a one-cycle write strobe into a small transmit FIFO. A framing state machine takes them out in write order and shifts each one onto the line. The frame shape comes from a format word. That word sets the number of data bits (6, 7 or 8), the parity kind (even, odd, forced 0, forced 1 or none) and the stop length (1, 1.5 or 2 bit times). A single-cycle baud tick paces the machine. Every bit lasts a fixed number of ticks (16 by default).

A two-bit channel field picks what drives the outgoing line and the line handed to the local receiver. In normal operation the transmitter drives the line. Automatic echo drives the incoming line straight back out. Local loopback sends the transmitter's output inward only and holds the pin idle. Remote loopback sends the incoming line back out and isolates the local receiver.

Command strobes control the block. They enable or disable the transmitter, clear it together with its FIFO, and start or end a break that forces the transmitter output low. Three registered flags report FIFO empty, FIFO full and frame activity.

Top module: `uart_frame_tx`

## Requirements
- R1: After reset the outgoing line is 1, `tx_empty` is 1, `tx_full` is 0 and `tx_active` is 0, and the transmitter is disabled.
- R2: A frame is a start bit of 0, then the data bits least significant first, each bit lasting OVS baud ticks. The data-length field `fmt_word[2:1]` selects the length: 00 gives 8 bits, 10 gives 7 bits and 11 gives 6 bits.
- R3: The parity field `fmt_word[5:3]` controls the optional bit that follows the data. 000 gives even parity, where the total count of ones is even. 001 gives odd parity. 010 gives a constant 0. 011 gives a constant 1. 1xx sends no parity bit.
- R4: The stop field `fmt_word[7:6]` sets the high stop period: 00 gives OVS ticks, 01 gives 1.5*OVS ticks and 10 gives 2*OVS ticks. If a byte is waiting when the stop period ends, its start bit begins at once. Consecutive start edges are therefore exactly (1 + data bits + parity bits)*OVS + stop ticks apart.
- R5: Bytes are sent in the order written. `tx_full` rises once DEPTH bytes are held. A write made while `tx_full` is 1 is discarded.
- R6: A new frame begins only while the transmitter is enabled. When the enable and disable strobes arrive together, disable takes effect. A disable that arrives during a frame lets that frame finish, and no further frame starts.
- R7: The transmit-clear strobe empties the FIFO and abandons any frame. On the next cycle `tx_empty` is 1 and `tx_active` is 0, and the line returns to 1.
- R8: The break-start strobe holds the transmitter output at 0 until a break-stop strobe arrives. If both strobes arrive together, the stop takes effect.
- R9: Channel field `fmt_word[9:8]` = 01 (echo): `line_out` and `rx_path` both copy `line_in` with one cycle of delay.
- R10: Channel field = 10 (local loopback): `line_out` stays 1, and the transmitted frames appear on `rx_path`.
- R11: Channel field = 11 (remote loopback): `line_out` copies `line_in` with one cycle of delay, and `rx_path` stays 1.
- R12: `tx_active` is 1 from the tick that starts a start bit until the tick that ends the last stop bit with no byte waiting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fmt_word | input | 9 | Format bits [9:1]: channel [9:8], stop [7:6], parity [5:3], length [2:1] |
| cmd_tx_en | input | 1 | Strobe: enable the transmitter |
| cmd_tx_dis | input | 1 | Strobe: disable the transmitter (dominant) |
| cmd_tx_clr | input | 1 | Strobe: clear the transmitter and its FIFO |
| cmd_brk_on | input | 1 | Strobe: begin a break |
| cmd_brk_off | input | 1 | Strobe: end a break (dominant) |
| wr_valid | input | 1 | Write strobe for one byte |
| wr_data | input | 8 | Byte to queue |
| baud_tick | input | 1 | One-cycle pulse per oversample slot |
| line_in | input | 1 | Incoming serial line |
| line_out | output | 1 | Outgoing serial line (registered) |
| rx_path | output | 1 | Line presented to the local receiver (registered) |
| tx_empty | output | 1 | FIFO holds no byte |
| tx_full | output | 1 | FIFO holds DEPTH bytes |
| tx_active | output | 1 | A frame is being shifted out |

## Verification
Every change in the framer's state occurs on a baud tick. The outgoing line follows one cycle later, because the line selector adds its own register stage. Every bit therefore has the same offset from its tick. The bench finds each start edge on a cycle boundary. It then samples bit k at 8 + 16k ticks after that edge, which is the middle of the bit, and compares the cycle distance between start edges with the exact frame length. The status flags and the channel paths update on the edge that samples their cause. The bench drives each stimulus at a falling edge and reads the result at the next falling edge.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

  localparam int DATA_W = 8;

  typedef enum logic [2:0] {
    FS_IDLE,
    FS_START,
    FS_DATA,
    FS_PARITY,
    FS_STOP
  } frame_state_e;

  typedef enum logic [1:0] {
    CH_NORMAL = 2'b00,
    CH_ECHO   = 2'b01,
    CH_LOCAL  = 2'b10,
    CH_REMOTE = 2'b11
  } chan_mode_e;

  typedef struct packed {
    logic [3:0] nbits;
    logic       par_en;
    logic [1:0] par_kind;
    logic [1:0] stop_sel;
  } frame_cfg_t;

  // Format bits [7:1] to frame shape
  function automatic frame_cfg_t decode_fmt(input logic [7:1] f);
    frame_cfg_t c;
    c.nbits    = f[2] ? (f[1] ? 4'd6 : 4'd7) : 4'd8;
    c.par_en   = ~f[5];
    c.par_kind = f[4:3];
    c.stop_sel = f[7:6];
    return c;
  endfunction

endpackage

// File: rtl/uart_tx_fifo.sv
module uart_tx_fifo
  import uart_tx_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic              empty,
  output logic              full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wp, rp;
  logic [CW-1:0]     cnt, cnt_n;
  logic              push, pop;

  assign push = wr_en && !full;
  assign pop  = rd_en && !empty;
  assign cnt_n = cnt + CW'(push) - CW'(pop);

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= wr_data;
  end

  assign rd_data = mem[rp];

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      wp    <= '0;
      rp    <= '0;
      cnt   <= '0;
      empty <= 1'b1;
      full  <= 1'b0;
    end else begin
      if (push) wp <= (wp == LAST) ? '0 : wp + 1'b1;
      if (pop)  rp <= (rp == LAST) ? '0 : rp + 1'b1;
      cnt   <= cnt_n;
      empty <= (cnt_n == '0);
      full  <= (cnt_n == CW'(DEPTH));
    end
  end
endmodule

// File: rtl/uart_tx_parity.sv
module uart_tx_parity
  import uart_tx_pkg::*;
(
  input  logic [DATA_W-1:0] data,
  input  logic [3:0]        nbits,
  input  logic [1:0]        kind,
  output logic              par_bit
);
  logic [DATA_W-1:0] masked;
  logic              ones;

  always_comb begin
    for (int i = 0; i < DATA_W; i++) begin
      masked[i] = data[i] && (4'(i) < nbits);
    end
    ones = ^masked;
    case (kind)
      2'b00:   par_bit = ones;
      2'b01:   par_bit = ~ones;
      2'b10:   par_bit = 1'b0;
      default: par_bit = 1'b1;
    endcase
  end
endmodule

// File: rtl/uart_tx_framer.sv
module uart_tx_framer
  import uart_tx_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              tick,
  input  logic              enable,
  input  logic              fifo_empty,
  input  logic [DATA_W-1:0] fifo_data,
  input  logic [7:1]        fmt,
  output logic              pop,
  output logic              bit_out,
  output logic              busy
);
  localparam int TW = $clog2(2 * OVS);
  localparam logic [TW-1:0] BIT_M1  = TW'(OVS - 1);
  localparam logic [TW-1:0] HALF_M1 = TW'(OVS + OVS / 2 - 1);
  localparam logic [TW-1:0] TWO_M1  = TW'(2 * OVS - 1);

  frame_cfg_t        cfg_now;
  frame_state_e      st;
  logic [TW-1:0]     cnt, len_m1, stop_m1;
  logic [DATA_W-1:0] shreg;
  logic [3:0]        idx, nb_q;
  logic [1:0]        ss_q;
  logic              pe_q, par_q, par_now, can_start, last_slot;

  assign cfg_now = decode_fmt(fmt);

  uart_tx_parity u_par (
    .data    (fifo_data),
    .nbits   (cfg_now.nbits),
    .kind    (cfg_now.par_kind),
    .par_bit (par_now)
  );

  always_comb begin
    case (ss_q)
      2'b00:   stop_m1 = BIT_M1;
      2'b01:   stop_m1 = HALF_M1;
      default: stop_m1 = TWO_M1;
    endcase
    len_m1    = (st == FS_STOP) ? stop_m1 : BIT_M1;
    last_slot = (cnt == len_m1);
    can_start = enable && !fifo_empty;
    pop       = can_start && tick &&
                ((st == FS_IDLE) || ((st == FS_STOP) && last_slot));
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      st      <= FS_IDLE;
      cnt     <= '0;
      idx     <= '0;
      shreg   <= '0;
      nb_q    <= 4'd8;
      ss_q    <= 2'b00;
      pe_q    <= 1'b0;
      par_q   <= 1'b0;
      bit_out <= 1'b1;
      busy    <= 1'b0;
    end else if (tick) begin
      if (pop) begin
        st      <= FS_START;
        cnt     <= '0;
        idx     <= '0;
        shreg   <= fifo_data;
        nb_q    <= cfg_now.nbits;
        ss_q    <= cfg_now.stop_sel;
        pe_q    <= cfg_now.par_en;
        par_q   <= par_now;
        bit_out <= 1'b0;
        busy    <= 1'b1;
      end else if (st == FS_IDLE) begin
        cnt <= '0;
      end else if (!last_slot) begin
        cnt <= cnt + 1'b1;
      end else begin
        cnt <= '0;
        case (st)
          FS_START: begin
            st      <= FS_DATA;
            idx     <= '0;
            bit_out <= shreg[0];
            shreg   <= shreg >> 1;
          end
          FS_DATA: begin
            if (idx == nb_q - 4'd1) begin
              st      <= pe_q ? FS_PARITY : FS_STOP;
              bit_out <= pe_q ? par_q : 1'b1;
            end else begin
              idx     <= idx + 4'd1;
              bit_out <= shreg[0];
              shreg   <= shreg >> 1;
            end
          end
          FS_PARITY: begin
            st      <= FS_STOP;
            bit_out <= 1'b1;
          end
          default: begin
            st      <= FS_IDLE;
            bit_out <= 1'b1;
            busy    <= 1'b0;
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/uart_tx_line_sel.sv
module uart_tx_line_sel
  import uart_tx_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] chan,
  input  logic       brk_on,
  input  logic       brk_off,
  input  logic       frame_bit,
  input  logic       line_in,
  output logic       line_out,
  output logic       rx_path
);
  logic brk_q, tx_src, out_n, rx_n;

  assign tx_src = brk_q ? 1'b0 : frame_bit;

  always_comb begin
    case (chan_mode_e'(chan))
      CH_NORMAL: begin out_n = tx_src;  rx_n = line_in; end
      CH_ECHO:   begin out_n = line_in; rx_n = line_in; end
      CH_LOCAL:  begin out_n = 1'b1;    rx_n = tx_src;  end
      default:   begin out_n = line_in; rx_n = 1'b1;    end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      brk_q    <= 1'b0;
      line_out <= 1'b1;
      rx_path  <= 1'b1;
    end else begin
      if (brk_off)     brk_q <= 1'b0;
      else if (brk_on) brk_q <= 1'b1;
      line_out <= out_n;
      rx_path  <= rx_n;
    end
  end
endmodule

// File: rtl/uart_frame_tx.sv
module uart_frame_tx
  import uart_tx_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int OVS   = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [9:1]        fmt_word,
  input  logic              cmd_tx_en,
  input  logic              cmd_tx_dis,
  input  logic              cmd_tx_clr,
  input  logic              cmd_brk_on,
  input  logic              cmd_brk_off,
  input  logic              wr_valid,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              baud_tick,
  input  logic              line_in,
  output logic              line_out,
  output logic              rx_path,
  output logic              tx_empty,
  output logic              tx_full,
  output logic              tx_active
);
  logic              tx_on, pop, frame_bit;
  logic [DATA_W-1:0] head;

  always_ff @(posedge clk) begin
    if (rst)             tx_on <= 1'b0;
    else if (cmd_tx_dis) tx_on <= 1'b0;
    else if (cmd_tx_en)  tx_on <= 1'b1;
  end

  uart_tx_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk     (clk),
    .rst     (rst),
    .clr     (cmd_tx_clr),
    .wr_en   (wr_valid),
    .wr_data (wr_data),
    .rd_en   (pop),
    .rd_data (head),
    .empty   (tx_empty),
    .full    (tx_full)
  );

  uart_tx_framer #(.OVS(OVS)) u_framer (
    .clk        (clk),
    .rst        (rst),
    .clr        (cmd_tx_clr),
    .tick       (baud_tick),
    .enable     (tx_on),
    .fifo_empty (tx_empty),
    .fifo_data  (head),
    .fmt        (fmt_word[7:1]),
    .pop        (pop),
    .bit_out    (frame_bit),
    .busy       (tx_active)
  );

  uart_tx_line_sel u_line (
    .clk       (clk),
    .rst       (rst),
    .chan      (fmt_word[9:8]),
    .brk_on    (cmd_brk_on),
    .brk_off   (cmd_brk_off),
    .frame_bit (frame_bit),
    .line_in   (line_in),
    .line_out  (line_out),
    .rx_path   (rx_path)
  );
endmodule

// File: rtl/uart_frame_tx_chk.sv
module uart_frame_tx_chk (
  input logic       clk,
  input logic       rst,
  input logic [9:8] chan,
  input logic       cmd_tx_clr,
  input logic       cmd_brk_on,
  input logic       cmd_brk_off,
  input logic       line_in,
  input logic       line_out,
  input logic       rx_path,
  input logic       tx_empty,
  input logic       tx_full,
  input logic       tx_active
);
  p_flags_excl_r5: assert property (@(posedge clk) disable iff (rst)
    !(tx_full && tx_empty));

  p_clear_r7: assert property (@(posedge clk) disable iff (rst)
    cmd_tx_clr |=> (tx_empty && !tx_active));

  p_break_low_r8: assert property (@(posedge clk) disable iff (rst)
    (cmd_brk_on && !cmd_brk_off) ##1 (!cmd_brk_off && chan == 2'b00)
    |=> !line_out);

  p_echo_r9: assert property (@(posedge clk) disable iff (rst)
    (chan == 2'b01) |=> (line_out == $past(line_in) && rx_path == $past(line_in)));

  p_local_r10: assert property (@(posedge clk) disable iff (rst)
    (chan == 2'b10) |=> line_out);

  p_remote_r11: assert property (@(posedge clk) disable iff (rst)
    (chan == 2'b11) |=> (rx_path && line_out == $past(line_in)));
endmodule

bind uart_frame_tx uart_frame_tx_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .chan        (fmt_word[9:8]),
  .cmd_tx_clr  (cmd_tx_clr),
  .cmd_brk_on  (cmd_brk_on),
  .cmd_brk_off (cmd_brk_off),
  .line_in     (line_in),
  .line_out    (line_out),
  .rx_path     (rx_path),
  .tx_empty    (tx_empty),
  .tx_full     (tx_full),
  .tx_active   (tx_active)
);

// File: tb/test_uart_frame_tx.sv
`timescale 1ns/1ps
module test_uart_frame_tx;
  localparam int DEPTH = 4;
  localparam int OVS   = 16;
  localparam int TP    = 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [9:1] fmt_word = '0;
  logic       cmd_tx_en = 0, cmd_tx_dis = 0, cmd_tx_clr = 0, cmd_brk_on = 0, cmd_brk_off = 0;
  logic       wr_valid = 0;
  logic [7:0] wr_data = '0;
  logic       baud_tick = 0;
  logic       line_in = 1'b1;
  logic       line_out, rx_path, tx_empty, tx_full, tx_active;

  int    errors = 0, checks = 0;
  longint cyc = 0;
  bit    saw_low = 0, saw_high = 0;

  uart_frame_tx #(.DEPTH(DEPTH), .OVS(OVS)) i_uart_frame_tx (
    .clk(clk), .rst(rst), .fmt_word(fmt_word),
    .cmd_tx_en(cmd_tx_en), .cmd_tx_dis(cmd_tx_dis), .cmd_tx_clr(cmd_tx_clr),
    .cmd_brk_on(cmd_brk_on), .cmd_brk_off(cmd_brk_off),
    .wr_valid(wr_valid), .wr_data(wr_data), .baud_tick(baud_tick),
    .line_in(line_in), .line_out(line_out), .rx_path(rx_path),
    .tx_empty(tx_empty), .tx_full(tx_full), .tx_active(tx_active)
  );

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) begin
    if (!line_out) saw_low = 1;
    if (line_out)  saw_high = 1;
  end

  initial begin
    forever begin
      for (int k = 0; k < TP; k++) begin
        @(negedge clk);
        baud_tick = (k == 0);
      end
    end
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] b);
    @(negedge clk); wr_valid = 1; wr_data = b;
    @(negedge clk); wr_valid = 0;
  endtask

  // c = {en, dis, clr, brk_on, brk_off}
  task automatic cmd(input logic [4:0] c);
    @(negedge clk);
    {cmd_tx_en, cmd_tx_dis, cmd_tx_clr, cmd_brk_on, cmd_brk_off} = c;
    @(negedge clk);
    {cmd_tx_en, cmd_tx_dis, cmd_tx_clr, cmd_brk_on, cmd_brk_off} = '0;
  endtask

  function automatic logic pick(input bit sel);
    return sel ? rx_path : line_out;
  endfunction

  // Receive one frame on line_out (sel=0) or rx_path (sel=1)
  task automatic get_frame(input bit sel, input int nb, input bit pe,
                           output logic [7:0] d, output logic pb,
                           output logic sb, output longint tf, output bit ok);
    logic prev, cur;
    ok = 0; d = '0; pb = 0; sb = 0; tf = 0;
    prev = pick(sel);
    for (int w = 0; w < 4000; w++) begin
      @(negedge clk);
      cur = pick(sel);
      if (prev && !cur) begin ok = 1; break; end
      prev = cur;
    end
    if (!ok) return;
    tf = cyc;
    repeat (8 * TP) @(negedge clk);
    for (int i = 0; i < nb; i++) begin
      repeat (OVS * TP) @(negedge clk);
      d[i] = pick(sel);
    end
    if (pe) begin
      repeat (OVS * TP) @(negedge clk);
      pb = pick(sel);
    end
    repeat (OVS * TP) @(negedge clk);
    sb = pick(sel);
  endtask

  function automatic logic exp_par(input logic [7:0] dm, input int pk);
    case (pk)
      0: return ^dm;
      1: return ~^dm;
      2: return 1'b0;
      default: return 1'b1;
    endcase
  endfunction

  initial begin
    logic [7:0] d1, d2, b1, b2, mask;
    logic p1, p2, s1, s2;
    longint t1, t2;
    bit ok1, ok2;
    int nb, stk;
    logic [1:0] lcode;

    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    check(line_out == 1 && tx_empty == 1 && tx_full == 0 && tx_active == 0,
          "R1 reset flags", {line_out, tx_empty, tx_full, tx_active}, 4'b1100);

    // R6: disabled after reset, byte held
    fmt_word = 9'b00_00_100_00;
    wr(8'h3C);
    saw_low = 0;
    repeat (200) @(negedge clk);
    check(!saw_low && !tx_active && !tx_empty, "R6 disabled after reset", saw_low, 0);
    cmd(5'b11000);
    saw_low = 0;
    repeat (200) @(negedge clk);
    check(!saw_low && !tx_active, "R6 disable wins", saw_low, 0);
    cmd(5'b10000);
    get_frame(0, 8, 0, d1, p1, s1, t1, ok1);
    check(ok1 && d1 == 8'h3C && s1, "R6 enabled sends", d1, 8'h3C);

    // R2 R3 R4 sweep
    for (int li = 0; li < 3; li++) begin
      for (int pk = 0; pk < 5; pk++) begin
        for (int sk = 0; sk < 3; sk++) begin
          lcode = (li == 0) ? 2'b00 : (li == 1) ? 2'b10 : 2'b11;
          nb    = (li == 0) ? 8 : (li == 1) ? 7 : 6;
          stk   = (sk == 0) ? OVS : (sk == 1) ? OVS + OVS / 2 : 2 * OVS;
          mask  = 8'((1 << nb) - 1);
          fmt_word = {2'b00, 2'(sk), 3'(pk), lcode};
          b1 = 8'((li * 15 + pk * 3 + sk) * 37 + 5);
          b2 = b1 ^ 8'hA5;
          wr(b1);
          wr(b2);
          get_frame(0, nb, pk < 4, d1, p1, s1, t1, ok1);
          get_frame(0, nb, pk < 4, d2, p2, s2, t2, ok2);
          check(ok1 && ok2, "R2 frames seen", {ok1, ok2}, 3);
          check((d1 & mask) == (b1 & mask), "R2 data first", d1 & mask, b1 & mask);
          check((d2 & mask) == (b2 & mask), "R2 data second", d2 & mask, b2 & mask);
          if (pk < 4) begin
            check(p1 == exp_par(b1 & mask, pk), "R3 parity first", p1, exp_par(b1 & mask, pk));
            check(p2 == exp_par(b2 & mask, pk), "R3 parity second", p2, exp_par(b2 & mask, pk));
          end
          check(s1 && s2, "R4 stop level", {s1, s2}, 3);
          check(t2 - t1 == longint'((OVS * (1 + nb + ((pk < 4) ? 1 : 0)) + stk) * TP),
                "R4 frame spacing", t2 - t1, (OVS * (1 + nb + ((pk < 4) ? 1 : 0)) + stk) * TP);
          wait (tx_active == 0);
          @(negedge clk);
          check(tx_empty && line_out, "R12 idle after frames", tx_active, 0);
        end
      end
    end

    // R5 full and drop
    fmt_word = 9'b00_00_100_00;
    cmd(5'b01000);
    for (int i = 0; i < DEPTH; i++) wr(8'(8'h10 + i));
    check(tx_full == 1 && tx_empty == 0, "R5 full at depth", tx_full, 1);
    wr(8'hEE);
    check(tx_full == 1, "R5 full after drop", tx_full, 1);
    cmd(5'b10000);
    for (int i = 0; i < DEPTH; i++) begin
      get_frame(0, 8, 0, d1, p1, s1, t1, ok1);
      check(ok1 && d1 == 8'(8'h10 + i), "R5 order", d1, 8'h10 + i);
    end
    wait (tx_active == 0);
    saw_low = 0;
    repeat (1000) @(negedge clk);
    check(!saw_low && tx_empty, "R5 dropped byte not sent", saw_low, 0);

    // R6 disable mid-frame, R12 active
    cmd(5'b01000);
    wr(8'h5A);
    wr(8'h69);
    cmd(5'b10000);
    fork
      get_frame(0, 8, 0, d1, p1, s1, t1, ok1);
      begin
        wait (tx_active == 1);
        @(negedge clk);
        check(tx_active == 1, "R12 active in frame", tx_active, 1);
        cmd(5'b01000);
      end
    join
    check(ok1 && d1 == 8'h5A && s1, "R6 frame completes", d1, 8'h5A);
    wait (tx_active == 0);
    saw_low = 0;
    repeat (1000) @(negedge clk);
    check(!saw_low && !tx_active && !tx_empty, "R6 no start after disable", saw_low, 0);

    // R7 clear
    cmd(5'b00100);
    check(tx_empty && !tx_active && line_out, "R7 clear idle", tx_empty, 1);
    cmd(5'b10000);
    wr(8'h00);
    wait (tx_active == 1);
    repeat (20) @(negedge clk);
    cmd(5'b00100);
    check(tx_empty && !tx_active, "R7 clear mid-frame flags", tx_active, 0);
    @(negedge clk);
    check(line_out == 1, "R7 line high after clear", line_out, 1);

    // R8 break
    cmd(5'b00010);
    @(negedge clk);
    saw_high = 0;
    repeat (300) @(negedge clk);
    check(!saw_high, "R8 break holds low", saw_high, 0);
    cmd(5'b00011);
    @(negedge clk);
    check(line_out == 1, "R8 stop wins", line_out, 1);

    // R9 echo
    fmt_word = 9'b01_00_100_00;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk); line_in = (8'b1011_0010 >> i) & 1;
      @(negedge clk);
      check(line_out == line_in && rx_path == line_in, "R9 echo", line_out, line_in);
    end

    // R11 remote
    fmt_word = 9'b11_00_100_00;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk); line_in = (8'b0110_1001 >> i) & 1;
      @(negedge clk);
      check(line_out == line_in && rx_path == 1, "R11 remote", {line_out, rx_path}, {line_in, 1'b1});
    end
    line_in = 1;

    // R10 local loopback
    fmt_word = 9'b10_00_100_00;
    @(negedge clk);
    saw_low = 0;
    wr(8'hC3);
    get_frame(1, 8, 0, d1, p1, s1, t1, ok1);
    check(ok1 && d1 == 8'hC3, "R10 loop data", d1, 8'hC3);
    check(!saw_low, "R10 pin idle", saw_low, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(190000 * 5);
    errors++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule